// File: doc/BRIEF.md
# Cache Index-Invalidate Unit

This block carries out a privileged cache-maintenance operation. The operation drops one line of a small data cache, and the line is picked by a raw set index and way number rather than by looking up a tag. The caller hands over a 32-bit instruction word, a flag that says whether the core is in supervisor mode, and the current contents of the base address register that the word names. The unit decodes the word and works out an index/way value in one of three addressing modes. It marks the selected line as neither valid nor dirty, and it reports whether the base register must be updated and to what value. A modified line is dropped with its contents: nothing is ever written back.

The unit holds the valid and dirty state of every line. A fill port marks a line as present, and a probe port reads back the state of any one line. Through these two ports a surrounding cache, or a testbench, can install lines and then watch them being dropped. A request is taken when `req_valid` is high and `req_ready` is high. Its result appears as a one-cycle `done` strobe on the following cycle. The unit does not take a new request while that strobe is showing.

Top module: `cidx_inval_unit`

## Requirements
- R1: A request is recognised as this operation only when instr[7:0] equals 0x89. The base register number is reported on `wb_reg` from instr[15:12]. The value of instr[11:8] never changes any result.
- R2: The signed 10-bit offset is built from instr[31:28] as its bits 9:6 and instr[21:16] as its bits 5:0. It is then sign-extended to 32 bits, so it covers -512 to +511.
- R3: With instr[27:22] = 0x2A (offset mode), the index/way is base + offset and `wb_en` stays low.
- R4: With instr[27:22] = 0x0A (post-update mode), the index/way is the unmodified base, `wb_en` is high and `wb_data` is base + offset.
- R5: With instr[27:22] = 0x1A (pre-update mode), the index/way is base + offset, `wb_en` is high and `wb_data` carries that same sum.
- R6: An executed operation clears both the valid and the dirty bit of the line whose way is index[1:0] and whose set is index[8:5] (the defaults: 4 ways, 16 sets, 32-byte lines). This happens whether or not the line was present, and every other line keeps its state.
- R7: A legal request made with `supervisor` low pulses `trap_priv` together with `done`. It leaves every line unchanged and keeps `wb_en` low.
- R8: A request with any other value in instr[7:0] or instr[27:22] pulses `illegal_op` together with `done`. It has no effect on the lines or on `wb_en`, and it does not raise `trap_priv`, whatever the supervisor flag is.
- R9: `done` is high for exactly the one cycle after an accepted request, and `req_ready` is low during that cycle.
- R10: After reset every line is invalid and clean, `req_ready` is high, and `done`, `wb_en`, `trap_priv` and `illegal_op` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| instr | input | 32 | Instruction word |
| supervisor | input | 1 | Caller is in supervisor mode |
| base_val | input | 32 | Current value of the named base register |
| fill_en | input | 1 | Mark a line present |
| fill_set | input | 4 | Set index of the line to mark |
| fill_way | input | 2 | Way of the line to mark |
| fill_dirty | input | 1 | Dirty state given to the marked line |
| probe_set | input | 4 | Set index to read back |
| probe_way | input | 2 | Way to read back |
| probe_valid | output | 1 | Valid bit of the probed line |
| probe_dirty | output | 1 | Dirty bit of the probed line |
| done | output | 1 | Result strobe |
| wb_en | output | 1 | Base register must be written |
| wb_reg | output | 4 | Base register number |
| wb_data | output | 32 | New base register value |
| inv_index | output | 32 | Computed index/way value |
| trap_priv | output | 1 | Privilege violation |
| illegal_op | output | 1 | Unrecognised encoding |

## Verification
The assertions assume that `req_valid` is only raised while the caller also drives a stable instruction, flag and base value, and that the request is dropped once it has been accepted. They also assume that a fill never targets the line being dropped in the same cycle. The stimulus meets these assumptions because a single driver task waits for `req_ready`, holds the inputs for exactly one accepting edge, and issues fills only between requests. The chosen bases and offsets reach both ends of the offset range, wrap past the top of the address space, and hit both present and empty lines.

// File: rtl/cidx_pkg.sv
package cidx_pkg;

   localparam int unsigned OFF_W = 10;
   localparam logic [7:0]  PRIM_OPCODE = 8'h89;

   typedef enum logic [5:0] {
      SUB_OFFSET = 6'h2A,
      SUB_POST   = 6'h0A,
      SUB_PRE    = 6'h1A
   } sub_op_e;

   typedef enum logic [1:0] {
      AM_OFFSET,
      AM_POST,
      AM_PRE,
      AM_NONE
   } amode_e;

   typedef struct packed {
      logic             legal;
      amode_e           mode;
      logic [3:0]       breg;
      logic [OFF_W-1:0] off;
   } dec_t;

endpackage

// File: rtl/cidx_decode.sv
module cidx_decode
   import cidx_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);

   logic [5:0] sub_field;
   logic       prim_ok;
   logic       pad_unused;

   assign sub_field  = instr[27:22];
   assign prim_ok    = (instr[7:0] == PRIM_OPCODE);
   assign pad_unused = ^instr[11:8];

   always_comb begin
      dec.breg  = instr[15:12];
      dec.off   = {instr[31:28], instr[21:16]};
      dec.mode  = AM_NONE;
      dec.legal = 1'b0;
      if (prim_ok) begin
         unique case (sub_field)
            SUB_OFFSET: begin dec.mode = AM_OFFSET; dec.legal = 1'b1; end
            SUB_POST:   begin dec.mode = AM_POST;   dec.legal = 1'b1; end
            SUB_PRE:    begin dec.mode = AM_PRE;    dec.legal = 1'b1; end
            default:    begin dec.mode = AM_NONE;   dec.legal = 1'b0; end
         endcase
      end
   end

endmodule

// File: rtl/cidx_agu.sv
module cidx_agu
   import cidx_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
)(
   input  logic [ADDR_W-1:0] base_val,
   input  amode_e            mode,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] index_way,
   output logic [ADDR_W-1:0] new_base,
   output logic              wb_need
);

   localparam int unsigned EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] sum;

   assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
   assign sum     = base_val + off_ext;

   always_comb begin
      new_base = sum;
      unique case (mode)
         AM_POST: begin index_way = base_val; wb_need = 1'b1; end
         AM_PRE:  begin index_way = sum;      wb_need = 1'b1; end
         default: begin index_way = sum;      wb_need = 1'b0; end
      endcase
   end

endmodule

// File: rtl/cidx_line_state.sv
module cidx_line_state #(
   parameter  int unsigned SETS  = 16,
   parameter  int unsigned WAYS  = 4,
   localparam int unsigned SET_W = $clog2(SETS),
   localparam int unsigned WAY_W = $clog2(WAYS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             fill_dirty,
   input  logic             inv_en,
   input  logic [SET_W-1:0] inv_set,
   input  logic [WAY_W-1:0] inv_way,
   input  logic [SET_W-1:0] probe_set,
   input  logic [WAY_W-1:0] probe_way,
   output logic             probe_valid,
   output logic             probe_dirty
);

   localparam int unsigned LINES = SETS * WAYS;

   logic [LINES-1:0] vld;
   logic [LINES-1:0] drt;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic set_fill, set_inv;
      assign set_fill = fill_en && (fill_set == SET_W'(s));
      assign set_inv  = inv_en  && (inv_set  == SET_W'(s));
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic v_q, d_q;
         logic hit_fill, hit_inv;
         assign hit_fill = set_fill && (fill_way == WAY_W'(w));
         assign hit_inv  = set_inv  && (inv_way  == WAY_W'(w));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= 1'b0;
            end else if (hit_inv) begin
               v_q <= 1'b0;
               d_q <= 1'b0;
            end else if (hit_fill) begin
               v_q <= 1'b1;
               d_q <= fill_dirty;
            end
         end
         assign vld[s*WAYS + w] = v_q;
         assign drt[s*WAYS + w] = d_q;
      end
   end

   assign probe_valid = vld[{probe_set, probe_way}];
   assign probe_dirty = drt[{probe_set, probe_way}];

endmodule

// File: rtl/cidx_inval_unit.sv
module cidx_inval_unit
   import cidx_pkg::*;
#(
   parameter  int unsigned ADDR_W     = 32,
   parameter  int unsigned SETS       = 16,
   parameter  int unsigned WAYS       = 4,
   parameter  int unsigned LINE_BYTES = 32,
   localparam int unsigned SET_W      = $clog2(SETS),
   localparam int unsigned WAY_W      = $clog2(WAYS),
   localparam int unsigned LOFS_W     = $clog2(LINE_BYTES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       instr,
   input  logic              supervisor,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              fill_en,
   input  logic [SET_W-1:0]  fill_set,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic              fill_dirty,
   input  logic [SET_W-1:0]  probe_set,
   input  logic [WAY_W-1:0]  probe_way,
   output logic              probe_valid,
   output logic              probe_dirty,
   output logic              done,
   output logic              wb_en,
   output logic [3:0]        wb_reg,
   output logic [ADDR_W-1:0] wb_data,
   output logic [ADDR_W-1:0] inv_index,
   output logic              trap_priv,
   output logic              illegal_op
);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < WAYS) begin : g_bad_line
      $error("LINE_BYTES must be a power of two no smaller than WAYS");
   end
   if (ADDR_W <= OFF_W || ADDR_W < LOFS_W + SET_W) begin : g_bad_addr
      $error("ADDR_W too narrow for offset or set field");
   end

   dec_t              dec;
   logic [ADDR_W-1:0] index_way;
   logic [ADDR_W-1:0] new_base;
   logic              wb_need;
   logic              busy_q;
   logic              accept;
   logic              inv_go;
   logic [SET_W-1:0]  inv_set;
   logic [WAY_W-1:0]  inv_way;

   cidx_decode u_decode (
      .instr (instr),
      .dec   (dec)
   );

   cidx_agu #(.ADDR_W(ADDR_W)) u_agu (
      .base_val  (base_val),
      .mode      (dec.mode),
      .off       (dec.off),
      .index_way (index_way),
      .new_base  (new_base),
      .wb_need   (wb_need)
   );

   assign inv_way = index_way[WAY_W-1:0];
   assign inv_set = index_way[LOFS_W +: SET_W];
   assign accept  = req_valid && !busy_q;
   assign inv_go  = accept && dec.legal && supervisor;

   cidx_line_state #(.SETS(SETS), .WAYS(WAYS)) u_lines (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_en     (fill_en),
      .fill_set    (fill_set),
      .fill_way    (fill_way),
      .fill_dirty  (fill_dirty),
      .inv_en      (inv_go),
      .inv_set     (inv_set),
      .inv_way     (inv_way),
      .probe_set   (probe_set),
      .probe_way   (probe_way),
      .probe_valid (probe_valid),
      .probe_dirty (probe_dirty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         wb_en      <= 1'b0;
         wb_reg     <= '0;
         wb_data    <= '0;
         inv_index  <= '0;
         trap_priv  <= 1'b0;
         illegal_op <= 1'b0;
      end else if (accept) begin
         busy_q     <= 1'b1;
         wb_en      <= dec.legal && supervisor && wb_need;
         wb_reg     <= dec.breg;
         wb_data    <= new_base;
         inv_index  <= index_way;
         trap_priv  <= dec.legal && !supervisor;
         illegal_op <= !dec.legal;
      end else begin
         busy_q     <= 1'b0;
         wb_en      <= 1'b0;
         trap_priv  <= 1'b0;
         illegal_op <= 1'b0;
      end
   end

   assign done      = busy_q;
   assign req_ready = !busy_q;

endmodule

// File: rtl/cidx_inval_chk.sv
module cidx_inval_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic done,
   input logic wb_en,
   input logic trap_priv,
   input logic illegal_op
);

   a_r9_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> done);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_not_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);

   a_r7_trap_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      trap_priv |-> (done && !wb_en));

   a_r8_illegal_alone: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> (done && !wb_en && !trap_priv));

   a_r4_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);

   a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $countones({wb_en, trap_priv, illegal_op}) == 0);

endmodule

bind cidx_inval_unit cidx_inval_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .done       (done),
   .wb_en      (wb_en),
   .trap_priv  (trap_priv),
   .illegal_op (illegal_op)
);

// File: tb/cidx_inval_unit_tb.sv
module cidx_inval_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] instr = '0;
   logic        supervisor = 1'b0;
   logic [31:0] base_val = '0;
   logic        fill_en = 1'b0;
   logic [3:0]  fill_set = '0;
   logic [1:0]  fill_way = '0;
   logic        fill_dirty = 1'b0;
   logic [3:0]  probe_set = '0;
   logic [1:0]  probe_way = '0;
   logic        probe_valid, probe_dirty;
   logic        done, wb_en, trap_priv, illegal_op;
   logic [3:0]  wb_reg;
   logic [31:0] wb_data, inv_index;

   always #10 clk = ~clk;

   cidx_inval_unit u_dut (.*);

   typedef struct {
      logic        wb_en;
      logic [3:0]  breg;
      logic [31:0] wbd;
      logic [31:0] idx;
      logic        exec;
      logic        trap;
      logic        ill;
      string       rq;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   m_valid[16][4];
   bit   m_dirty[16][4];
   bit   finished = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   function automatic logic [31:0] mk(input logic [5:0] sub, input logic [9:0] off,
                                      input logic [3:0] b, input logic [3:0] pad,
                                      input logic [7:0] prim);
      return {off[9:6], sub, off[5:0], b, pad, prim};
   endfunction

   // monitor: pops expected results as done strobes appear
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && prev_done) chk(0, "R9", "done held two cycles", 1, 0);
         if (done) begin
            chk(!req_ready, "R9", "ready during done", {31'b0, req_ready}, 0);
            if (exp_q.size() == 0) chk(0, "R9", "unexpected done", 1, 0);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(wb_en == e.wb_en, e.rq, "wb_en", {31'b0, wb_en}, {31'b0, e.wb_en});
               chk(trap_priv == e.trap, e.rq, "trap_priv", {31'b0, trap_priv}, {31'b0, e.trap});
               chk(illegal_op == e.ill, e.rq, "illegal_op", {31'b0, illegal_op}, {31'b0, e.ill});
               if (e.exec) begin
                  chk(inv_index == e.idx, e.rq, "inv_index", inv_index, e.idx);
                  chk(wb_reg == e.breg, e.rq, "wb_reg", {28'b0, wb_reg}, {28'b0, e.breg});
               end
               if (e.wb_en) chk(wb_data == e.wbd, e.rq, "wb_data", wb_data, e.wbd);
            end
         end
         prev_done = done;
      end
   end

   task automatic issue(input logic [31:0] ins, input logic sup,
                        input logic [31:0] base, input string rq);
      exp_t e;
      logic [9:0]  off;
      logic [31:0] sx, sum;
      logic [5:0]  sub;
      bit          legal;
      sub   = ins[27:22];
      off   = {ins[31:28], ins[21:16]};
      sx    = {{22{off[9]}}, off};
      sum   = base + sx;
      legal = (ins[7:0] == 8'h89) && (sub == 6'h2A || sub == 6'h0A || sub == 6'h1A);
      e.rq   = rq;
      e.ill  = !legal;
      e.trap = legal && !sup;
      e.exec = legal && sup;
      e.breg = ins[15:12];
      e.wbd  = sum;
      e.idx  = (sub == 6'h0A) ? base : sum;
      e.wb_en = e.exec && (sub != 6'h2A);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      instr = ins; supervisor = sup; base_val = base; req_valid = 1'b1;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
      chk(done, "R9", "done one cycle after accept", {31'b0, done}, 1);
      if (e.exec) begin
         m_valid[e.idx[8:5]][e.idx[1:0]] = 0;
         m_dirty[e.idx[8:5]][e.idx[1:0]] = 0;
      end
   endtask

   task automatic fill(input int s, input int w, input bit d);
      @(negedge clk);
      fill_en = 1'b1; fill_set = 4'(s); fill_way = 2'(w); fill_dirty = d;
      @(negedge clk);
      fill_en = 1'b0;
      m_valid[s][w] = 1; m_dirty[s][w] = d;
   endtask

   task automatic sweep(input string rq);
      for (int s = 0; s < 16; s++) begin
         for (int w = 0; w < 4; w++) begin
            probe_set = 4'(s); probe_way = 2'(w);
            #1;
            chk(probe_valid == m_valid[s][w], rq, $sformatf("valid s%0d w%0d", s, w),
                {31'b0, probe_valid}, {31'b0, m_valid[s][w]});
            chk(probe_dirty == m_dirty[s][w], rq, $sformatf("dirty s%0d w%0d", s, w),
                {31'b0, probe_dirty}, {31'b0, m_dirty[s][w]});
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 1, 0);
      wrap_up();
   end

   initial begin
      for (int s = 0; s < 16; s++)
         for (int w = 0; w < 4; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(req_ready == 1, "R10", "ready after reset", {31'b0, req_ready}, 1);
      chk(done == 0 && wb_en == 0 && trap_priv == 0 && illegal_op == 0, "R10",
          "strobes low in reset", {28'b0, done, wb_en, trap_priv, illegal_op}, 0);
      sweep("R10");
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R10");

      fill(3, 1, 1); fill(3, 2, 0); fill(0, 0, 1); fill(15, 3, 1);
      fill(5, 2, 1); fill(7, 0, 0);

      // R3 R6: offset mode, 0x60 + 1 -> set 3 way 1 (dirty line dropped)
      issue(mk(6'h2A, 10'd1, 4'd3, 4'd0, 8'h89), 1, 32'h60, "R3");
      sweep("R6");

      // R5 R2: pre-update with negative offset, 0x200 - 0x1D = 0x1E3 -> set 15 way 3
      issue(mk(6'h1A, 10'h3E3, 4'd7, 4'd0, 8'h89), 1, 32'h200, "R5");
      // R4 R2: post-update, index = base 0, largest positive offset
      issue(mk(6'h0A, 10'h1FF, 4'd2, 4'd0, 8'h89), 1, 32'h0, "R4");
      // R2: most negative offset
      issue(mk(6'h0A, 10'h200, 4'd2, 4'd0, 8'h89), 1, 32'h1000, "R2");
      // R3: wrap past the top of the address space
      issue(mk(6'h2A, 10'h020, 4'd1, 4'd0, 8'h89), 1, 32'hFFFF_FFF0, "R3");
      sweep("R6");

      // R6: empty line at set 7 way 1; neighbour set 7 way 0 keeps its state
      issue(mk(6'h2A, 10'h0, 4'd4, 4'd0, 8'h89), 1, 32'hE1, "R6");
      sweep("R6");

      // R7: privilege trap, line at set 5 way 2 untouched
      issue(mk(6'h1A, 10'h2, 4'd5, 4'd0, 8'h89), 0, 32'hA0, "R7");
      sweep("R7");

      // R8: bad secondary opcode, bad primary, bad opcode with supervisor low
      issue(mk(6'h3A, 10'h2, 4'd5, 4'd0, 8'h89), 1, 32'hA0, "R8");
      issue(mk(6'h1A, 10'h2, 4'd5, 4'd0, 8'h88), 1, 32'hA0, "R8");
      issue(mk(6'h00, 10'h2, 4'd5, 4'd0, 8'h89), 0, 32'hA0, "R8");
      sweep("R8");

      // R1: bits 11:8 set, base register number 0xA
      issue(mk(6'h1A, 10'h2, 4'hA, 4'hF, 8'h89), 1, 32'hA0, "R1");
      sweep("R1");

      // R9: back-to-back requests
      fill(9, 1, 1);
      issue(mk(6'h0A, 10'h4, 4'd6, 4'd0, 8'h89), 1, 32'h121, "R9");
      issue(mk(6'h2A, 10'h4, 4'd6, 4'd0, 8'h89), 1, 32'h121, "R9");
      sweep("R9");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
      wrap_up();
   end

endmodule